// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Sequencer

This block times the refresh traffic of a DRAM or synchronous DRAM controller. A periodic request tick causes it to issue one refresh command. The command is followed by a programmable count of extra wait states. The count is the same for every region that is set up as DRAM or synchronous DRAM. If a memory access is in flight when the tick arrives, the request is held until the bus goes quiet. While the block works, a busy flag tells the bus arbiter to keep other traffic off the memory.

When the system goes into standby with refresh enabled and self-refresh armed, the block does not keep refreshing. It puts the memory into self-refresh instead and holds it there until the standby exit strobe arrives. It then issues the exit command and a precharge period. That precharge is the base count lengthened by a programmable extension. Recovery disarms self-refresh, so software must arm it again before the next standby. A normal precharge request uses the base count alone.

The controller is one state machine with these states:
- `ST_IDLE`
- `ST_REF` (refresh command)
- `ST_RWAIT` (refresh wait states)
- `ST_SRE` (self-refresh entry command)
- `ST_SELF` (memory in self-refresh)
- `ST_SRX` (self-refresh exit command)
- `ST_PRE` (precharge)

Its transitions are:
- IDLE→SRE on an armed standby.
- IDLE→REF on a pending or fresh refresh tick.
- IDLE→PRE on a precharge request.
- All three IDLE transitions happen only when the bus is free, and they take priority in that order.
- REF→RWAIT when the wait count is non-zero, and REF→IDLE when it is zero.
- RWAIT→IDLE when the wait timer expires.
- SRE→SELF unconditionally.
- SELF→SRX on the exit strobe.
- SRX→PRE with the extended count.
- PRE→IDLE when the timer expires.

Top module: `dram_refresh_seq`

## Requirements
- R1: With the refresh wait field at w (0 to 3), each refresh shows `mem_cmd` = REF for exactly one cycle, followed by w cycles of NOP. `busy` is high for exactly 1+w cycles in total.
- R2: The control word has these fields: bit 0 refresh enable, bits 2:1 refresh wait, bit 3 self-refresh arm, bits 6:4 self-refresh precharge extension. `cfg_rdata` returns the stored word. A refresh tick while refresh enable is 0 starts nothing.
- R3: A standby entry strobe with refresh enable and arm both 1 produces SRE for one cycle. The block then holds NOP with `busy` high until `standby_exit`. After that strobe it produces SRX for one cycle.
- R4: If arm is 1 but refresh enable is 0, a standby entry strobe leaves `busy` low and `mem_cmd` at NOP.
- R5: Leaving self-refresh clears the arm bit, and `cfg_rdata` bit 3 reads 0 afterwards.
- R6: A refresh tick that arrives while `access_busy` is high is held. REF appears in the cycle after the first clock edge at which `access_busy` is sampled low.
- R7: A `pre_req` pulse while idle gives PRE for exactly `pre_base`+1 cycles.
- R8: The precharge after SRX lasts `pre_base`+1+ext cycles, where ext is the extension field.
- R9: Refresh ticks that arrive during self-refresh are discarded, and no REF follows the recovery.
- R10: A write to the wait field during a refresh sequence does not change that sequence's length. It takes effect from the next refresh.
- R11: After synchronous reset, `mem_cmd` is NOP, `busy` is 0 and `cfg_rdata` is 0.
- R12: The `mem_cmd` encodings are NOP=0, REF=1, SRE=2, SRX=3 and PRE=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word write data |
| cfg_rdata | output | 7 | Control word readback |
| pre_base | input | 2 | Base precharge count |
| refresh_tick | input | 1 | Periodic refresh request pulse |
| access_busy | input | 1 | A memory access is in progress |
| pre_req | input | 1 | Normal precharge request pulse |
| standby_enter | input | 1 | Standby entry strobe |
| standby_exit | input | 1 | Standby exit strobe |
| mem_cmd | output | 3 | Memory command (NOP, REF, SRE, SRX, PRE) |
| busy | output | 1 | Sequencer owns the memory |

## Verification
The hardest case to reach from the ports is a full self-refresh round trip in which several things happen together. Refresh ticks must land while the memory sleeps, the recovery precharge must use the extension, and the arm bit must be cleared by hardware. The bench reaches it by arming through the register port and strobing standby entry. It then pulses ticks during the sleep and measures the PRE run after the exit strobe against base+1+ext, with random base and extension values. Finally it reads back the control word and watches for a stray refresh. Timing of held requests is reached by raising `access_busy` around a tick. The snapshot rule is reached by writing the wait field in the cycle a refresh command is on the bus.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
    localparam int WAIT_W   = 2;
    localparam int EXT_W    = 3;
    localparam int BASE_W   = 2;
    localparam int REN_BIT  = 0;
    localparam int WAIT_LSB = REN_BIT + 1;
    localparam int ARM_BIT  = WAIT_LSB + WAIT_W;
    localparam int EXT_LSB  = ARM_BIT + 1;
    localparam int CFG_W    = EXT_LSB + EXT_W;
    localparam int CNT_MAX  = (2 ** BASE_W) + (2 ** EXT_W) - 1;
    localparam int CNT_W    = $clog2(CNT_MAX + 1);

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_REF = 3'd1,
        CMD_SRE = 3'd2,
        CMD_SRX = 3'd3,
        CMD_PRE = 3'd4
    } mem_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REF,
        ST_RWAIT,
        ST_SRE,
        ST_SELF,
        ST_SRX,
        ST_PRE
    } seq_state_e;
endpackage

// File: rtl/rfs_cfg_regs.sv
module rfs_cfg_regs
    import rfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [CFG_W-1:0]  wdata,
    input  logic              clr_arm,
    output logic              ref_en,
    output logic [WAIT_W-1:0] wait_cnt,
    output logic              arm,
    output logic [EXT_W-1:0]  ext,
    output logic [CFG_W-1:0]  rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ref_en   <= 1'b0;
            wait_cnt <= '0;
            arm      <= 1'b0;
            ext      <= '0;
        end else begin
            if (we) begin
                ref_en   <= wdata[REN_BIT];
                wait_cnt <= wdata[WAIT_LSB +: WAIT_W];
                ext      <= wdata[EXT_LSB +: EXT_W];
            end
            // hardware disarm on recovery wins over a software write
            if (clr_arm)
                arm <= 1'b0;
            else if (we)
                arm <= wdata[ARM_BIT];
        end
    end

    always_comb begin
        rdata                     = '0;
        rdata[REN_BIT]            = ref_en;
        rdata[WAIT_LSB +: WAIT_W] = wait_cnt;
        rdata[ARM_BIT]            = arm;
        rdata[EXT_LSB +: EXT_W]   = ext;
    end

    assert_disarm_R5: assert property (@(posedge clk) disable iff (rst)
        clr_arm |=> !arm);
endmodule

// File: rtl/rfs_req_latch.sv
module rfs_req_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic pend
);
    always_ff @(posedge clk) begin
        if (rst)
            pend <= 1'b0;
        else if (clr)
            pend <= 1'b0;
        else if (set)
            pend <= 1'b1;
    end
endmodule

// File: rtl/rfs_timer.sv
module rfs_timer
    import rfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);
    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign last = (cnt == CNT_W'(1));
endmodule

// File: rtl/dram_refresh_seq.sv
module dram_refresh_seq
    import rfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic [BASE_W-1:0] pre_base,
    input  logic              refresh_tick,
    input  logic              access_busy,
    input  logic              pre_req,
    input  logic              standby_enter,
    input  logic              standby_exit,
    output logic [2:0]        mem_cmd,
    output logic              busy
);
    seq_state_e        state_q, state_d;
    logic              ref_en, arm;
    logic [WAIT_W-1:0] wait_reg, wait_snap;
    logic [EXT_W-1:0]  ext_reg, ext_snap;
    logic              clr_arm;
    logic              ref_pend, stby_pend, pre_pend;
    logic              ref_set, ref_clr, stby_set, stby_clr, pre_clr;
    logic              ref_go, sr_go, pre_go, in_self;
    logic              tmr_load, tmr_last;
    logic [CNT_W-1:0]  tmr_val, tmr_cnt;
    mem_cmd_e          cmd;

    rfs_cfg_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .clr_arm  (clr_arm),
        .ref_en   (ref_en),
        .wait_cnt (wait_reg),
        .arm      (arm),
        .ext      (ext_reg),
        .rdata    (cfg_rdata)
    );

    rfs_req_latch u_ref_pend  (.clk(clk), .rst(rst), .set(ref_set),  .clr(ref_clr),  .pend(ref_pend));
    rfs_req_latch u_stby_pend (.clk(clk), .rst(rst), .set(stby_set), .clr(stby_clr), .pend(stby_pend));
    rfs_req_latch u_pre_pend  (.clk(clk), .rst(rst), .set(pre_req),  .clr(pre_clr),  .pend(pre_pend));

    rfs_timer u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    assign in_self  = (state_q == ST_SRE) || (state_q == ST_SELF) || (state_q == ST_SRX);
    assign ref_set  = refresh_tick && ref_en && !in_self;
    assign stby_set = standby_enter && ref_en && arm;
    assign ref_go   = ref_pend || ref_set;
    assign sr_go    = (stby_pend || stby_set) && ref_en && arm;
    assign pre_go   = pre_pend || pre_req;
    assign clr_arm  = (state_q == ST_SRX);

    // next state, timer loads and request clears
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ref_clr  = in_self;
        stby_clr = !(ref_en && arm);
        pre_clr  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!access_busy) begin
                    if (sr_go) begin
                        state_d  = ST_SRE;
                        stby_clr = 1'b1;
                        ref_clr  = 1'b1;
                    end else if (ref_go) begin
                        state_d = ST_REF;
                        ref_clr = 1'b1;
                    end else if (pre_go) begin
                        state_d  = ST_PRE;
                        pre_clr  = 1'b1;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(pre_base) + CNT_W'(1);
                    end
                end
            end
            ST_REF: begin
                if (wait_snap == '0) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d  = ST_RWAIT;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(wait_snap);
                end
            end
            ST_RWAIT: if (tmr_last) state_d = ST_IDLE;
            ST_SRE:   state_d = ST_SELF;
            ST_SELF:  if (standby_exit) state_d = ST_SRX;
            ST_SRX: begin
                state_d  = ST_PRE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(pre_base) + CNT_W'(1) + CNT_W'(ext_snap);
            end
            ST_PRE:   if (tmr_last) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register with per-sequence snapshots of the control fields
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            wait_snap <= '0;
            ext_snap  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_REF) wait_snap <= wait_reg;
            if (state_q == ST_IDLE && state_d == ST_SRE) ext_snap  <= ext_reg;
        end
    end

    // outputs decoded from the state
    always_comb begin
        cmd  = CMD_NOP;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_REF:   cmd  = CMD_REF;
            ST_RWAIT: cmd  = CMD_NOP;
            ST_SRE:   cmd  = CMD_SRE;
            ST_SELF:  cmd  = CMD_NOP;
            ST_SRX:   cmd  = CMD_SRX;
            ST_PRE:   cmd  = CMD_PRE;
            default:  busy = 1'b0;
        endcase
    end
    assign mem_cmd = cmd;

    assert_ref_bus_free_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_REF) |-> $past(!access_busy));
    assert_sre_enabled_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_SRE) |-> $past(ref_en && arm));
    assert_srx_to_pre_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_cmd == CMD_SRX) |=> (mem_cmd == CMD_PRE));
    assert_no_ref_asleep_R9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SELF) |=> (mem_cmd != CMD_REF));
    assert_timer_live_R1: assert property (@(posedge clk) disable iff (rst)
        ((state_q == ST_RWAIT) || (state_q == ST_PRE)) |-> (tmr_cnt != '0));
    assert_snap_held_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_RWAIT) |-> $stable(wait_snap));
endmodule

// File: tb/dram_refresh_seq_tb.sv
module dram_refresh_seq_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic [6:0] cfg_rdata;
    logic [1:0] pre_base = '0;
    logic       refresh_tick = 1'b0;
    logic       access_busy = 1'b0;
    logic       pre_req = 1'b0;
    logic       standby_enter = 1'b0;
    logic       standby_exit = 1'b0;
    logic [2:0] mem_cmd;
    logic       busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dram_refresh_seq u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .pre_base(pre_base), .refresh_tick(refresh_tick),
        .access_busy(access_busy), .pre_req(pre_req), .standby_enter(standby_enter),
        .standby_exit(standby_exit), .mem_cmd(mem_cmd), .busy(busy)
    );

    function automatic int exp_ref_len(int w);
        return 1 + w;
    endfunction

    function automatic int exp_pre_len(int base, int ext, bit after_sleep);
        return base + 1 + (after_sleep ? ext : 0);
    endfunction

    function automatic logic [6:0] word(int en, int w, int arm, int ext);
        return {3'(ext), 1'(arm), 2'(w), 1'(en)};
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(logic [6:0] w);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic run_refresh(output int len, output int refs);
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
        len = 0;
        refs = 0;
        while (busy && len < 64) begin
            if (mem_cmd == 3'd1) refs++;
            len++;
            @(negedge clk);
        end
    endtask

    task automatic count_pre(output int n);
        n = 0;
        while (mem_cmd == 3'd4 && n < 64) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic sleep_round(int base, int ext);
        int n;
        int seen_ref;
        pre_base = 2'(base);
        wr(word(1, 1, 1, ext));
        standby_enter = 1'b1;
        @(negedge clk);
        standby_enter = 1'b0;
        chk("R3 entry cmd", int'(mem_cmd), 2);
        @(negedge clk);
        chk("R3 asleep cmd", int'(mem_cmd), 0);
        chk("R3 asleep busy", int'(busy), 1);
        seen_ref = 0;
        for (int i = 0; i < 3; i++) begin
            refresh_tick = 1'b1;
            @(negedge clk);
            refresh_tick = 1'b0;
            if (mem_cmd == 3'd1) seen_ref++;
            @(negedge clk);
        end
        chk("R9 no refresh asleep", seen_ref, 0);
        standby_exit = 1'b1;
        @(negedge clk);
        standby_exit = 1'b0;
        chk("R3 exit cmd", int'(mem_cmd), 3);
        @(negedge clk);
        count_pre(n);
        chk("R8 recovery precharge", n, exp_pre_len(base, ext, 1'b1));
        chk("R5 arm cleared", int'(cfg_rdata[3]), 0);
        seen_ref = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy) seen_ref++;
            @(negedge clk);
        end
        chk("R9 no refresh after recovery", seen_ref, 0);
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int len, refs, n, w, base, ext;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R11 reset cmd", int'(mem_cmd), 0);
        chk("R11 reset busy", int'(busy), 0);
        chk("R11 reset rdata", int'(cfg_rdata), 0);

        // R2: tick ignored while refresh disabled; readback layout
        run_refresh(len, refs);
        chk("R2 disabled tick", len, 0);
        wr(word(1, 2, 1, 5));
        chk("R2 readback", int'(cfg_rdata), 93);
        wr(word(0, 0, 0, 0));

        // R1, R12: every wait setting
        for (int i = 0; i < 4; i++) begin
            wr(word(1, i, 0, 0));
            run_refresh(len, refs);
            chk("R1 refresh length", len, exp_ref_len(i));
            chk("R12 one REF code", refs, 1);
        end

        // R6: tick held behind an access
        access_busy = 1'b1;
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
        n = 0;
        for (int i = 0; i < 4; i++) begin
            if (busy) n++;
            @(negedge clk);
        end
        chk("R6 held during access", n, 0);
        access_busy = 1'b0;
        @(negedge clk);
        chk("R6 served when free", int'(mem_cmd), 1);
        while (busy) @(negedge clk);

        // R10: write mid-sequence
        wr(word(1, 3, 0, 0));
        refresh_tick = 1'b1;
        @(negedge clk);
        refresh_tick = 1'b0;
        chk("R10 start", int'(mem_cmd), 1);
        cfg_we = 1'b1;
        cfg_wdata = word(1, 0, 0, 0);
        len = 0;
        while (busy && len < 64) begin
            len++;
            @(negedge clk);
            cfg_we = 1'b0;
        end
        chk("R10 old length kept", len, exp_ref_len(3));
        run_refresh(len, refs);
        chk("R10 new length used", len, exp_ref_len(0));

        // R4: armed but refresh disabled
        wr(word(0, 0, 1, 3));
        standby_enter = 1'b1;
        @(negedge clk);
        standby_enter = 1'b0;
        n = 0;
        for (int i = 0; i < 3; i++) begin
            if (busy || mem_cmd != 3'd0) n++;
            @(negedge clk);
        end
        chk("R4 no self-refresh", n, 0);

        // R3 R5 R8 R9: directed corners then random
        sleep_round(3, 7);
        sleep_round(0, 0);
        for (int i = 0; i < 4; i++)
            sleep_round(int'($urandom_range(0, 3)), int'($urandom_range(0, 7)));

        // random refresh and precharge mix
        for (int i = 0; i < 12; i++) begin
            w = int'($urandom_range(0, 3));
            ext = int'($urandom_range(0, 7));
            wr(word(1, w, 0, ext));
            run_refresh(len, refs);
            chk("R1 random refresh", len, exp_ref_len(w));
            base = int'($urandom_range(0, 3));
            pre_base = 2'(base);
            pre_req = 1'b1;
            @(negedge clk);
            pre_req = 1'b0;
            count_pre(n);
            chk("R7 normal precharge", n, exp_pre_len(base, ext, 1'b0));
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule